// File: doc/BRIEF.md
# SPI Slave for a 32-Pin Analog/GPIO Monitoring Hub

This block is the device-side serial slave of a hub with 32 pins. Each pin can act as an analog input, a digital input or a digital output. A host talks to the block over SPI in mode 0. Every exchange uses 16-bit frames, bracketed by chip select and shifted MSB first. The block holds the per-pin configuration registers and drives the digital pins from them. It also answers two kinds of read:

- A sample read returns the 12-bit conversion value for a channel.
- A register read returns one byte of configuration or live input state.

Both kinds of read need two frames. The command goes out in the first frame. After chip select has been released and asserted again, the reply comes back in the second frame. The conversion results arrive on a wide sample bus, one 12-bit field per channel. That bus is level-sampled when a command frame completes and carries no handshake, so it never exerts back-pressure.

The SPI pins are oversampled by the system clock through synchronisers. For that reason the serial clock must stay well below the system clock, with each SCLK phase at least four system clocks long.

Top module: `spi_hub_slave`

## Requirements
- R1: After reset, all enable and output-value registers are zero. This makes `pin_oe` and `pin_out` zero and every pin an analog input. `spi_miso` is 0.
- R2: A frame is accepted only when it carries exactly 16 SCLK rising edges and bits 15:14 of the frame (bits 7:6 of the command byte) are zero. Any other frame changes no register and leaves a pending reply pending.
- R3: A frame whose command byte has bit 5 clear is a sample read of channel cmd[4:0]. Channels 0–15 are pins A0–A15, and channels 16–31 are pins B0–B15, which are pin numbers 16–31. The next accepted frame returns {0, flag, 00, sample[11:0]} MSB first. MOSI is ignored during that reply frame, and the frame is consumed without being decoded.
- R4: The flag in reply bit 14 is 1 when the requested pin has its input-enable or its output-enable bit set.
- R5: A command with bit 5 and bit 4 both set is a register read of address cmd[3:0]. The next frame returns {8'h00, value}.
- R6: A frame with command bit 5 set and bit 4 clear writes the low frame byte to register address cmd[3:0].
- R7: For pin p, the register address is 4·group + 3 − p/8, and the bit is p%8. The groups are: 0 input value, 1 input enable, 2 output enable, 3 output value.
- R8: Input-value addresses 0–3 return the live `pin_in` byte, and writes to them change nothing.
- R9: `pin_oe[p]` equals the output-enable bit of pin p. `pin_out[p]` is the output-value bit when that enable is set, and 0 otherwise.
- R10: The reply word is captured when the command frame ends. Later changes of the sample bus or the pins do not alter it.
- R11: `spi_miso` is 0 outside reply frames and during frames that carry no reply. Reply bits change only after SCLK falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host-to-device data |
| spi_miso | output | 1 | Device-to-host data |
| pin_in | input | 32 | Live digital level of each pin |
| pin_out | output | 32 | Driven level of each output pin |
| pin_oe | output | 32 | Per-pin output enable |
| adc_samples | input | 384 | 12-bit conversion result per channel, channel c at bits 12c+11:12c |

## Verification
A corrupted configuration byte shows on `pin_oe` or `pin_out` about five system clocks after the chip select of the write frame rises. It also shows in the status flag of the next sample read of any affected pin. A bank-mapping error moves the effect to a different byte of the pin vectors. Such an error is caught by writing each group to one A bank and one B bank and checking which pins respond. A stuck or lost pending-reply state misaligns every later reply by a frame, so the very next register read-back returns zero or a stale word.

// File: rtl/spi_hub_pkg.sv
package spi_hub_pkg;

  localparam int FRAME_W = 16;
  localparam int BYTE_W  = 8;

  typedef enum logic [1:0] {
    GRP_IN_VAL  = 2'd0,
    GRP_IN_EN   = 2'd1,
    GRP_OUT_EN  = 2'd2,
    GRP_OUT_VAL = 2'd3
  } reg_grp_e;

  // Lowest address of each group serves pins 24..31, highest serves 0..7.
  function automatic logic [1:0] bank_of(input logic [3:0] addr);
    return 2'd3 - addr[1:0];
  endfunction

endpackage

// File: rtl/spi_hub_frontend.sv
module spi_hub_frontend #(
  parameter int FRAME_W     = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(FRAME_W) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               mosi,
  input  logic [FRAME_W-1:0] load_word,
  output logic               miso,
  output logic               frame_done,
  output logic               frame_full,
  output logic [FRAME_W-1:0] rx_word
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [SYNC_STAGES-1:0] sclk_sy, cs_sy, mosi_sy;
  logic sclk_s, cs_s, mosi_s, sclk_d, cs_d;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] rx_q, tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk};
      cs_sy   <= {cs_sy[SYNC_STAGES-2:0], cs_n};
      mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], mosi};
      sclk_d  <= sclk_s;
      cs_d    <= cs_s;
    end
  end

  assign sclk_s = sclk_sy[SYNC_STAGES-1];
  assign cs_s   = cs_sy[SYNC_STAGES-1];
  assign mosi_s = mosi_sy[SYNC_STAGES-1];

  logic sclk_rise, sclk_fall, cs_fall, cs_rise;
  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_fall   = ~cs_s & cs_d;
  assign cs_rise   = cs_s & ~cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
      tx_q    <= load_word;
    end else if (cs_rise) begin
      tx_q    <= '0;
    end else if (!cs_s) begin
      if (sclk_rise) begin
        rx_q <= {rx_q[FRAME_W-2:0], mosi_s};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      end
      if (sclk_fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign miso       = tx_q[FRAME_W-1];
  assign frame_done = cs_rise;
  assign frame_full = (bit_cnt == CNT_FULL);
  assign rx_word    = rx_q;

  // R11
  miso_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && cs_d) |-> !miso);

  // R2
  rx_hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && cs_d) |=> $stable(rx_q));

endmodule

// File: rtl/spi_hub_pinregs.sv
module spi_hub_pinregs
  import spi_hub_pkg::*;
#(
  parameter int NPIN = 32,
  localparam int NBANK = NPIN / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [3:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pin_is_gpio
);

  logic [BYTE_W-1:0] in_en_q  [NBANK];
  logic [BYTE_W-1:0] out_en_q [NBANK];
  logic [BYTE_W-1:0] out_val_q[NBANK];
  logic [NPIN-1:0]   in_en_v, out_en_v, out_val_v;

  reg_grp_e  wr_grp, rd_grp;
  logic [1:0] wr_bank, rd_bank;
  assign wr_grp  = reg_grp_e'(wr_addr[3:2]);
  assign rd_grp  = reg_grp_e'(rd_addr[3:2]);
  assign wr_bank = bank_of(wr_addr);
  assign rd_bank = bank_of(rd_addr);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_en_q[b]   <= '0;
        out_en_q[b]  <= '0;
        out_val_q[b] <= '0;
      end else if (wr_en && wr_bank == 2'(b)) begin
        case (wr_grp)
          GRP_IN_EN:   in_en_q[b]   <= wr_data;
          GRP_OUT_EN:  out_en_q[b]  <= wr_data;
          GRP_OUT_VAL: out_val_q[b] <= wr_data;
          default: ;
        endcase
      end
    end
    assign in_en_v  [b*BYTE_W +: BYTE_W] = in_en_q[b];
    assign out_en_v [b*BYTE_W +: BYTE_W] = out_en_q[b];
    assign out_val_v[b*BYTE_W +: BYTE_W] = out_val_q[b];
  end

  always_comb begin
    case (rd_grp)
      GRP_IN_VAL:  rd_data = pin_in[rd_bank*BYTE_W +: BYTE_W];
      GRP_IN_EN:   rd_data = in_en_q[rd_bank];
      GRP_OUT_EN:  rd_data = out_en_q[rd_bank];
      default:     rd_data = out_val_q[rd_bank];
    endcase
  end

  assign pin_oe      = out_en_v;
  assign pin_out     = out_val_v & out_en_v;
  assign pin_is_gpio = in_en_v | out_en_v;

  // R6
  regs_hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(in_en_v) && $stable(out_en_v) && $stable(out_val_v)));

  // R8
  input_value_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[3:2] == 2'd0) |=>
      ($stable(in_en_v) && $stable(out_en_v) && $stable(out_val_v)));

endmodule

// File: rtl/spi_hub_cmd.sv
module spi_hub_cmd
  import spi_hub_pkg::*;
#(
  parameter int NCH   = 32,
  parameter int ADC_W = 12,
  localparam int CH_W = $clog2(NCH),
  localparam int PAD  = FRAME_W - 2 - ADC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done,
  input  logic               frame_full,
  input  logic [FRAME_W-1:0] rx_word,
  input  logic [NCH*ADC_W-1:0] adc_samples,
  input  logic [NCH-1:0]     pin_is_gpio,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic [3:0]         rd_addr,
  output logic               wr_en,
  output logic [3:0]         wr_addr,
  output logic [BYTE_W-1:0]  wr_data,
  output logic [FRAME_W-1:0] tx_word
);

  logic [BYTE_W-1:0] cmd;
  logic              accept, cmd_ok, is_reg, is_rd;
  logic [CH_W-1:0]   ch;
  logic [FRAME_W-1:0] adc_reply, reg_reply, reply_q;
  logic              pend_q;

  assign cmd    = rx_word[FRAME_W-1 -: BYTE_W];
  assign accept = frame_done & frame_full;
  assign cmd_ok = (cmd[7:6] == 2'b00);
  assign is_reg = cmd[5];
  assign is_rd  = ~is_reg | cmd[4];
  assign ch     = cmd[CH_W-1:0];

  assign rd_addr = cmd[3:0];
  assign wr_addr = cmd[3:0];
  assign wr_data = rx_word[BYTE_W-1:0];
  assign wr_en   = accept & ~pend_q & cmd_ok & is_reg & ~cmd[4];

  assign adc_reply = {1'b0, pin_is_gpio[ch], {PAD{1'b0}},
                      adc_samples[int'(ch)*ADC_W +: ADC_W]};
  assign reg_reply = {{(FRAME_W-BYTE_W){1'b0}}, rd_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      reply_q <= '0;
    end else if (accept) begin
      if (pend_q) begin
        pend_q <= 1'b0;
      end else if (cmd_ok && is_rd) begin
        pend_q  <= 1'b1;
        reply_q <= is_reg ? reg_reply : adc_reply;
      end
    end
  end

  assign tx_word = pend_q ? reply_q : '0;

  // R3
  reply_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pend_q) |=> !pend_q);

  // R2
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(pend_q) && $stable(reply_q)));

endmodule

// File: rtl/spi_hub_slave.sv
module spi_hub_slave
  import spi_hub_pkg::*;
#(
  parameter int NPIN  = 32,
  parameter int ADC_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_sclk,
  input  logic                  spi_cs_n,
  input  logic                  spi_mosi,
  output logic                  spi_miso,
  input  logic [NPIN-1:0]       pin_in,
  output logic [NPIN-1:0]       pin_out,
  output logic [NPIN-1:0]       pin_oe,
  input  logic [NPIN*ADC_W-1:0] adc_samples
);

  logic               frame_done, frame_full;
  logic [FRAME_W-1:0] rx_word, tx_word;
  logic               wr_en;
  logic [3:0]         wr_addr, rd_addr;
  logic [BYTE_W-1:0]  wr_data, rd_data;
  logic [NPIN-1:0]    pin_is_gpio;

  spi_hub_frontend #(.FRAME_W(FRAME_W), .SYNC_STAGES(2)) u_front (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .load_word(tx_word), .miso(spi_miso),
    .frame_done(frame_done), .frame_full(frame_full), .rx_word(rx_word)
  );

  spi_hub_cmd #(.NCH(NPIN), .ADC_W(ADC_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
    .frame_full(frame_full), .rx_word(rx_word), .adc_samples(adc_samples),
    .pin_is_gpio(pin_is_gpio), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .tx_word(tx_word)
  );

  spi_hub_pinregs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_is_gpio(pin_is_gpio)
  );

endmodule

// File: tb/test_spi_hub_slave.sv
module test_spi_hub_slave;

  localparam int NPIN = 32;
  localparam int AW   = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [NPIN-1:0] pin_in = '0, pin_out, pin_oe;
  logic [NPIN*AW-1:0] samples = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] m_in_en = '0, m_out_en = '0, m_out_val = '0;

  always #5 clk = ~clk;

  spi_hub_slave i_spi_hub_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .adc_samples(samples)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
    rx = '0;
    @(posedge clk); #2 cs_n = 1'b0;
    repeat (8) @(posedge clk);
    for (int i = 0; i < nbits; i++) begin
      @(posedge clk); #2 mosi = tx[15-i];
      repeat (6) @(posedge clk);
      #2 rx[15-i] = miso; sclk = 1'b1;
      repeat (8) @(posedge clk);
      #2 sclk = 1'b0;
    end
    repeat (8) @(posedge clk);
    #2 cs_n = 1'b1; mosi = 1'b0;
    repeat (10) @(posedge clk);
    #2;
  endtask

  function automatic logic [11:0] samp(input int ch, input int salt);
    return 12'((ch * 293 + salt * 71 + 17) % 4096);
  endfunction

  task automatic load_samples(input int salt);
    for (int c = 0; c < NPIN; c++) samples[c*AW +: AW] = samp(c, salt);
  endtask

  // Model update following R6/R7: group = addr/4, bank = 3 - addr%4
  task automatic wr_reg(input int addr, input logic [7:0] d);
    logic [15:0] r;
    int bank;
    xfer({4'h2, 4'(addr), d}, 16, r);
    bank = 3 - (addr % 4);
    case (addr / 4)
      1: m_in_en[bank*8 +: 8]   = d;
      2: m_out_en[bank*8 +: 8]  = d;
      3: m_out_val[bank*8 +: 8] = d;
      default: ;
    endcase
    chk("R11 no reply on write frame", {16'h0, r}, 32'h0);
  endtask

  task automatic rd_reg(input int addr, output logic [15:0] r);
    logic [15:0] dummy;
    xfer({4'h3, 4'(addr), 8'h00}, 16, dummy);
    xfer(16'h0000, 16, r);
  endtask

  task automatic rd_adc(input int ch, output logic [15:0] r);
    logic [15:0] dummy;
    xfer({3'b000, 5'(ch), 8'h00}, 16, dummy);
    xfer(16'h0000, 16, r);
  endtask

  function automatic logic [15:0] adc_exp(input int ch, input int salt);
    return {1'b0, (m_in_en[ch] | m_out_en[ch]), 2'b00, samp(ch, salt)};
  endfunction

  task automatic chk_pins(input string req);
    chk(req, pin_oe, m_out_en);
    chk(req, pin_out, m_out_val & m_out_en);
  endtask

  task automatic t_reset;
    logic [15:0] r;
    chk("R1 pin_oe after reset", pin_oe, 32'h0);
    chk("R1 pin_out after reset", pin_out, 32'h0);
    chk("R11 miso idle", {31'h0, miso}, 32'h0);
    rd_adc(5, r);
    chk("R1 flag clear after reset", {16'h0, r}, {16'h0, adc_exp(5, 0)});
  endtask

  task automatic t_adc;
    logic [15:0] r;
    int chs[4] = '{0, 15, 16, 31};
    foreach (chs[k]) begin
      rd_adc(chs[k], r);
      chk("R3 sample reply", {16'h0, r}, {16'h0, adc_exp(chs[k], 0)});
    end
  endtask

  task automatic t_bank_map;
    logic [15:0] r;
    wr_reg(11, 8'hFF);   // output enable, pins 0..7
    wr_reg(15, 8'hA5);   // output value, pins 0..7
    chk_pins("R7 R9 bank A0-7");
    wr_reg(8, 8'h81);    // output enable, pins 24..31
    wr_reg(12, 8'h01);   // output value, pins 24..31
    chk_pins("R7 R9 bank B8-15");
    rd_reg(11, r);
    chk("R5 read back out enable", {16'h0, r}, 32'h0000_00FF);
    rd_reg(12, r);
    chk("R5 read back out value", {16'h0, r}, 32'h0000_0001);
  endtask

  task automatic t_flag;
    logic [15:0] r;
    wr_reg(5, 8'h02);    // input enable pin 17
    chk_pins("R9 input pin not driven");
    rd_adc(17, r);
    chk("R4 flag on input pin", {16'h0, r}, {16'h0, adc_exp(17, 0)});
    chk("R4 flag bit value", {31'h0, r[14]}, 32'h1);
    rd_adc(16, r);
    chk("R4 flag clear on analog pin", {31'h0, r[14]}, 32'h0);
    rd_adc(0, r);
    chk("R4 flag on output pin", {31'h0, r[14]}, 32'h1);
  endtask

  task automatic t_gpi;
    logic [15:0] r;
    pin_in = 32'hC3A5_5A3C;
    rd_reg(3, r);
    chk("R8 live pins 0-7", {16'h0, r}, 32'h3C);
    rd_reg(0, r);
    chk("R8 live pins 24-31", {16'h0, r}, 32'hC3);
    wr_reg(3, 8'hFF);
    rd_reg(3, r);
    chk("R8 write to input value ignored", {16'h0, r}, 32'h3C);
    chk_pins("R8 write to input value no pin effect");
    pin_in = 32'h0000_0077;
    rd_reg(3, r);
    chk("R8 live update", {16'h0, r}, 32'h77);
  endtask

  task automatic t_frames;
    logic [15:0] r, dummy;
    xfer({8'h2B, 8'h00}, 12, dummy);  // short write to out enable 0..7
    chk_pins("R2 short frame discarded");
    xfer({8'h6B, 8'h00}, 16, dummy);  // bit 6 set in command
    chk_pins("R2 bad command bits discarded");
    xfer({8'h03, 8'h00}, 16, dummy);  // sample read ch 3
    xfer(16'h0000, 10, dummy);        // short frame keeps reply pending
    xfer(16'h0000, 16, r);
    chk("R2 reply survives short frame", {16'h0, r}, {16'h0, adc_exp(3, 0)});
  endtask

  task automatic t_latch;
    logic [15:0] r, dummy;
    xfer({8'h09, 8'h00}, 16, dummy);
    load_samples(1);
    xfer(16'h2B00, 16, r);            // write-shaped data during reply frame
    chk("R10 reply captured at command end", {16'h0, r}, {16'h0, adc_exp(9, 0)});
    chk_pins("R3 MOSI ignored in reply frame");
    rd_adc(9, r);
    chk("R3 new sample after update", {16'h0, r}, {16'h0, adc_exp(9, 1)});
    chk("R11 miso idle after frames", {31'h0, miso}, 32'h0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    load_samples(0);
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #2;
    t_reset;
    t_adc;
    t_bank_map;
    t_flag;
    t_gpi;
    t_frames;
    t_latch;
    done = 1'b1;
    summary;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary;
    end
  end

endmodule